// File: doc/BRIEF.md
# Inverter gate protection controller

This block sits between the six PWM commands of a three-phase bridge (an upper and a lower switch per phase) and the six gate-enable lines. It takes already-compared logic indications: a lower-rail supply undervoltage flag, one upper-bias undervoltage flag per phase, and an overcurrent trip. It gates the commands according to those indications and drives an active-low fault flag for a programmed number of clock cycles.

The two sides are protected differently. An overcurrent trip or lower-rail undervoltage shuts off every lower gate and pulls the fault flag low. An upper-bias undervoltage shuts off only that phase's upper gate and leaves the flag alone. Once protection has cleared a gate, removing the fault does not turn the gate back on. The gate needs a new low-to-high transition of its own command. This stops a switch from turning on in the middle of a PWM pulse.

Every input passes through a two-flop synchronizer. A command change therefore reaches its gate output three clock edges after it is sampled. The fault duration is a parameter in clock cycles. A second parameter sets a minimum duration that the first cannot go below.

Top module: `gate_guard`

## Requirements
- R1: Commands are active high. Once a gate is armed, its output equals its command delayed by three clock edges. A command raised at the ports shows at the gate after the third rising edge and not after the second. A low command always gives a low gate.
- R2: During and after reset, all gate outputs are 0 and `fault_n` is 1. A command held high through reset does not reach its gate until that command goes low and then high again.
- R3: While `uv_lo` is 1, all three lower gates are 0 and `fault_n` is 0. The upper gates are not affected.
- R4: While bit p of `uv_hi` is 1, `gate_hi[p]` is 0. `fault_n` stays 1 and every other gate output is unchanged.
- R5: An `sc_trip` pulse one cycle wide forces all lower gates to 0 and drives `fault_n` low for exactly D cycles. The upper gates are not affected. If `sc_trip` is held high for H cycles, `fault_n` is low for H+D-1 cycles.
- R6: A second trip that arrives while the flag is low restarts the count. Two one-cycle trips g cycles apart give a low time of g+D cycles.
- R7: When the flag returns high, a lower gate whose command stayed high remains 0. It turns on only after its command goes low and then high.
- R8: When `uv_hi[p]` clears, `gate_hi[p]` stays 0 while its command stays high. It turns on again after a fresh rising command edge.
- R9: D is the larger of FLT_CYCLES and FLT_MIN_CYCLES. For example, 9 and 14 give D=14.
- R10: When `uv_lo` rises and stays high for H cycles, `fault_n` is low for the larger of H and D cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_hi | input | NPH | Upper-switch PWM commands, one per phase |
| cmd_lo | input | NPH | Lower-switch PWM commands, one per phase |
| uv_lo | input | 1 | Lower-rail supply undervoltage indication, active high |
| uv_hi | input | NPH | Per-phase upper-bias undervoltage indications, active high |
| sc_trip | input | 1 | Overcurrent comparator trip, active high |
| gate_hi | output | NPH | Upper gate enables |
| gate_lo | output | NPH | Lower gate enables |
| fault_n | output | 1 | Fault flag, low while a lower-side fault is signalled |

## Verification
A bad arm bit shows up at the gate ports within three cycles of the command edge that should have been ignored or honoured. The bench catches it by holding commands high across each fault and checking that the gates stay off until the command is toggled. A timer that loads, clears or compares wrongly changes the low time of `fault_n`. The bench counts that time cycle by cycle against D, H+D-1, g+D and max(H, D), so an error of a single cycle fails a check. A blocking path wired to the wrong side or the wrong phase shows at the first sample inside a fault. At that point the bench compares every gate against the mask it expects.

// File: rtl/gate_guard_pkg.sv
package gate_guard_pkg;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic int unsigned dur_floor(input int unsigned req_v,
                                              input int unsigned floor_v);
        return (req_v < floor_v) ? floor_v : req_v;
    endfunction

endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= {WIDTH{RST_VAL}};
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= {WIDTH{RST_VAL}};
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gg_fault_timer.sv
module gg_fault_timer
    import gate_guard_pkg::*;
#(
    parameter int unsigned DUR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_sc,
    input  logic s_uv_lo,
    output logic lo_block,
    output logic fault_n
);

    localparam int unsigned CW = (DUR < 2) ? 1 : $clog2(DUR);

    typedef struct packed {
        tmr_state_e    st;
        logic [CW-1:0] cnt;
        logic          uv_prev;
        logic          fault_n;
    } tmr_t;

    tmr_t q, d;
    logic trigger;
    logic block_d;

    always_comb begin
        d         = q;
        d.uv_prev = s_uv_lo;
        trigger   = s_sc || (s_uv_lo && !q.uv_prev);
        if (trigger) begin
            d.st  = TMR_RUN;
            d.cnt = '0;
        end else if (q.st == TMR_RUN) begin
            if (q.cnt == CW'(DUR - 1)) begin
                d.st  = TMR_IDLE;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
        block_d   = (d.st == TMR_RUN) || s_uv_lo;
        d.fault_n = !block_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= TMR_IDLE;
            q.cnt     <= '0;
            q.uv_prev <= 1'b0;
            q.fault_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign lo_block = block_d;
    assign fault_n  = q.fault_n;

endmodule

// File: rtl/gg_rearm.sv
module gg_rearm (
    input  logic clk,
    input  logic rst_n,
    input  logic s_cmd,
    input  logic block,
    output logic gate
);

    typedef struct packed {
        logic prev;
        logic armed;
        logic gate;
    } arm_t;

    arm_t q, d;
    logic rise;

    always_comb begin
        d      = q;
        rise   = s_cmd && !q.prev;
        d.prev = s_cmd;
        if (block) begin
            d.armed = 1'b0;
            d.gate  = 1'b0;
        end else begin
            d.armed = q.armed || rise;
            d.gate  = s_cmd && (q.armed || rise);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.prev  <= 1'b1;
            q.armed <= 1'b0;
            q.gate  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign gate = q.gate;

endmodule

// File: rtl/gate_guard.sv
module gate_guard
    import gate_guard_pkg::*;
#(
    parameter int unsigned NPH            = 3,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned FLT_CYCLES     = 450000,
    parameter int unsigned FLT_MIN_CYCLES = 250000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] cmd_hi,
    input  logic [NPH-1:0] cmd_lo,
    input  logic           uv_lo,
    input  logic [NPH-1:0] uv_hi,
    input  logic           sc_trip,
    output logic [NPH-1:0] gate_hi,
    output logic [NPH-1:0] gate_lo,
    output logic           fault_n
);

    localparam int unsigned DUR_EFF = dur_floor(FLT_CYCLES, FLT_MIN_CYCLES);
    localparam int unsigned NCMD    = 2 * NPH;
    localparam int unsigned NFLT    = NPH + 2;

    logic [NCMD-1:0] s_cmd_all;
    logic [NFLT-1:0] s_flt_all;
    logic [NPH-1:0]  s_cmd_hi;
    logic [NPH-1:0]  s_cmd_lo;
    logic [NPH-1:0]  s_uv_hi;
    logic            s_uv_lo;
    logic            s_sc;
    logic            lo_block;

    gg_sync #(.WIDTH(NCMD), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cmd (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cmd_lo, cmd_hi}),
        .dout (s_cmd_all)
    );

    gg_sync #(.WIDTH(NFLT), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_flt (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sc_trip, uv_lo, uv_hi}),
        .dout (s_flt_all)
    );

    assign s_cmd_hi = s_cmd_all[NPH-1:0];
    assign s_cmd_lo = s_cmd_all[NCMD-1:NPH];
    assign s_uv_hi  = s_flt_all[NPH-1:0];
    assign s_uv_lo  = s_flt_all[NPH];
    assign s_sc     = s_flt_all[NPH+1];

    gg_fault_timer #(.DUR(DUR_EFF)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_sc    (s_sc),
        .s_uv_lo (s_uv_lo),
        .lo_block(lo_block),
        .fault_n (fault_n)
    );

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        gg_rearm u_hi (
            .clk  (clk),
            .rst_n(rst_n),
            .s_cmd(s_cmd_hi[p]),
            .block(s_uv_hi[p]),
            .gate (gate_hi[p])
        );
        gg_rearm u_lo (
            .clk  (clk),
            .rst_n(rst_n),
            .s_cmd(s_cmd_lo[p]),
            .block(lo_block),
            .gate (gate_lo[p])
        );
    end

endmodule

// File: rtl/gg_checker.sv
module gg_checker #(
    parameter int unsigned NPH = 3,
    parameter int unsigned DUR = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NPH-1:0] gate_hi,
    input logic [NPH-1:0] gate_lo,
    input logic           fault_n,
    input logic [NPH-1:0] s_cmd_hi,
    input logic [NPH-1:0] s_cmd_lo,
    input logic [NPH-1:0] s_uv_hi,
    input logic           s_uv_lo,
    input logic           s_sc
);

    logic [31:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          low_run_q <= '0;
        else if (fault_n || s_sc || s_uv_lo) low_run_q <= '0;
        else                                 low_run_q <= low_run_q + 32'd1;
    end

    AST_GATE_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_hi & ~$past(s_cmd_hi)) == '0) && ((gate_lo & ~$past(s_cmd_lo)) == '0)); // R1

    AST_LO_OFF_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (gate_lo == '0)); // R3

    AST_HI_UV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & $past(s_uv_hi)) == '0); // R4

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> $past(s_sc || s_uv_lo)); // R5

    AST_SC_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(s_sc) |-> (gate_lo == '0)); // R5

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= DUR); // R9

endmodule

bind gate_guard gg_checker #(.NPH(NPH), .DUR(DUR_EFF)) u_gg_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_hi (gate_hi),
    .gate_lo (gate_lo),
    .fault_n (fault_n),
    .s_cmd_hi(s_cmd_hi),
    .s_cmd_lo(s_cmd_lo),
    .s_uv_hi (s_uv_hi),
    .s_uv_lo (s_uv_lo),
    .s_sc    (s_sc)
);

// File: tb/test_gate_guard.sv
`timescale 1ns/1ps
module test_gate_guard;

    localparam int DUR = 14;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_hi = 3'b111;
    logic [2:0] cmd_lo = 3'b111;
    logic       uv_lo = 1'b0;
    logic [2:0] uv_hi = 3'b000;
    logic       sc = 1'b0;
    logic [2:0] gate_hi;
    logic [2:0] gate_lo;
    logic       fault_n;

    int total = 0;
    int bad = 0;
    int len;

    always #2 clk = ~clk;

    gate_guard #(.NPH(3), .SYNC_STAGES(2), .FLT_CYCLES(9), .FLT_MIN_CYCLES(14)) i_gate_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_hi (cmd_hi),
        .cmd_lo (cmd_lo),
        .uv_lo  (uv_lo),
        .uv_hi  (uv_hi),
        .sc_trip(sc),
        .gate_hi(gate_hi),
        .gate_lo(gate_lo),
        .fault_n(fault_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic measure_low(output int n);
        bit seen = 0;
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!fault_n) begin
                n++;
                seen = 1;
            end else if (seen) begin
                break;
            end
        end
    endtask

    task automatic rearm_lo();
        cmd_lo = 3'b000; settle();
        cmd_lo = 3'b111; settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R2 reset gate_hi", gate_hi, 0);
        chk("R2 reset gate_lo", gate_lo, 0);
        chk("R2 reset fault_n", fault_n, 1);
        rst_n = 1'b1;
        settle();
        chk("R2 held cmd hi blocked", gate_hi, 0);
        chk("R2 held cmd lo blocked", gate_lo, 0);
        chk("R2 fault_n idle", fault_n, 1);
        cmd_hi = 3'b000; cmd_lo = 3'b000; settle();
        chk("R2 after drop", {gate_lo, gate_hi}, 0);

        // R1 latency: raised at a negedge, visible after the third rising edge
        cmd_lo = 3'b010;
        repeat (2) @(negedge clk);
        chk("R1 latency two edges", gate_lo, 0);
        @(negedge clk);
        chk("R1 latency three edges", gate_lo, 2);
        cmd_lo = 3'b000; settle();

        // R1 sweep over all command patterns
        for (int v = 0; v < 64; v++) begin
            cmd_hi = v[2:0]; cmd_lo = v[5:3]; settle();
            chk("R1 sweep on", {gate_lo, gate_hi}, v);
            cmd_hi = 3'b000; cmd_lo = 3'b000; settle();
            chk("R1 sweep off", {gate_lo, gate_hi}, 0);
        end

        // R4 and R8: per-phase upper undervoltage masks
        for (int m = 0; m < 8; m++) begin
            cmd_hi = 3'b000; cmd_lo = 3'b000; settle();
            cmd_hi = 3'b111; cmd_lo = 3'b111; settle();
            uv_hi = m[2:0]; settle();
            chk("R4 hi masked", gate_hi, (~m) & 7);
            chk("R4 lo untouched", gate_lo, 7);
            chk("R4 no flag", fault_n, 1);
            uv_hi = 3'b000; settle();
            chk("R8 stays off after clear", gate_hi, (~m) & 7);
            cmd_hi = 3'b000; settle();
            cmd_hi = 3'b111; settle();
            chk("R8 fresh edge rearms", gate_hi, 7);
        end

        // R5 and R9: single-cycle trip
        fork
            begin
                sc = 1'b1; @(negedge clk); sc = 1'b0;
                repeat (5) @(negedge clk);
                chk("R5 lo off in trip", gate_lo, 0);
                chk("R5 hi kept in trip", gate_hi, 7);
            end
            measure_low(len);
        join
        chk("R5 R9 pulse width", len, DUR);
        settle();
        chk("R7 held cmd stays off", gate_lo, 0);
        rearm_lo();
        chk("R7 fresh edge rearms", gate_lo, 7);

        // R5 trip held high for 5 cycles
        fork
            begin sc = 1'b1; repeat (5) @(negedge clk); sc = 1'b0; end
            measure_low(len);
        join
        chk("R5 held trip width", len, DUR + 4);
        rearm_lo();

        // R6 retrigger 6 cycles after the first trip
        fork
            begin
                sc = 1'b1; @(negedge clk); sc = 1'b0;
                repeat (5) @(negedge clk);
                sc = 1'b1; @(negedge clk); sc = 1'b0;
            end
            measure_low(len);
        join
        chk("R6 restart width", len, DUR + 6);
        rearm_lo();
        chk("R6 rearmed", gate_lo, 7);

        // R3 and R10: short lower-rail undervoltage
        fork
            begin
                uv_lo = 1'b1; repeat (3) @(negedge clk); uv_lo = 1'b0;
                repeat (2) @(negedge clk);
                chk("R3 lo off", gate_lo, 0);
                chk("R3 hi kept", gate_hi, 7);
            end
            measure_low(len);
        join
        chk("R10 short uv width", len, DUR);
        settle();
        chk("R7 after uv held cmd off", gate_lo, 0);
        rearm_lo();

        // R10: long undervoltage outlasts the timer
        fork
            begin
                uv_lo = 1'b1; repeat (DUR + 10) @(negedge clk);
                chk("R3 lo off long uv", gate_lo, 0);
                chk("R3 flag low long uv", fault_n, 0);
                uv_lo = 1'b0;
            end
            measure_low(len);
        join
        chk("R10 long uv width", len, DUR + 10);
        rearm_lo();
        chk("R7 final rearm", gate_lo, 7);
        chk("R4 hi untouched overall", gate_hi, 7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule